// File: doc/BRIEF.md
# UART Baud Rate Generator

This block turns the system clock into the two timing strobes a UART needs. A 13-bit modulo divisor, split across a high-byte and a low-byte register, sets how many system clocks make one oversample interval. A 5-bit oversampling ratio input then sets how many oversample intervals make one serial bit. The block drives an oversample-rate tick and a bit-rate tick, and each tick is one system clock wide.

The divisor registers sit behind a small byte-wide write and read port. Writes to the divisor take effect only while the transmitter enable and the receiver enable are both low, so the rate cannot change under a frame in progress. The divisor resets to a nonzero value. Even so, the generator stays silent after reset until one of the two enables is raised for the first time. A divisor of zero stops the ticks altogether.

Top module: `baud_tick_gen`

## Requirements
- R1: With reg_sel=0 the port reaches the low divisor byte (divisor bits 7..0 in data bits 7..0). With reg_sel=1 it reaches the high byte, where data bits 4..0 are divisor bits 12..8. Bits 7..5 of the high byte read as 0 whatever was written. reg_rdata always shows the stored value of the byte selected by reg_sel.
- R2: After reset the low byte reads 0x04 and the high byte reads 0x00, so the divisor is 4.
- R3: After reset, neither tick fires while tx_en and rx_en have both stayed 0 since reset.
- R4: A write, made by holding reg_we=1 for one clock, is ignored while tx_en=1 or rx_en=1. The stored divisor and its readback stay unchanged.
- R5: While running with divisor BR (1 to 8191), ovs_tick is a one-clock pulse that repeats every BR clocks.
- R6: While running, bit_tick repeats every BR×(osr+1) clocks and is high only in a cycle where ovs_tick is also high.
- R7: A divisor of 0 produces no ticks, even with an enable set.
- R8: When tx_en and rx_en are both 0, no tick follows. Both counters return to their start values, so the first tick after re-enabling comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Divisor register write strobe |
| reg_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| osr | input | 5 | Oversampling ratio minus one (factor 1 to 32) |
| ovs_tick | output | 1 | Oversample-rate tick |
| bit_tick | output | 1 | Bit-rate tick |

## Verification
The bench measures tick spacing at the extremes: a divisor of 1 with no oversampling, where a design that holds the tick high or miscounts by one breaks the every-clock rhythm; an oversampling factor of 32; and a divisor that needs the high byte, which exposes swapped or truncated byte lanes as a wrong period. It tries writes under each enable separately, to catch a lock that watches only one of them. It also runs a zero divisor, which a design that wraps its counter would turn into a very slow tick instead of none. Finally it checks the quiet periods after reset and after disable, where a design that counts before the first enable or keeps counting would emit stray ticks.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned BR_W    = 13;
  localparam int unsigned OSR_W   = 5;
  localparam int unsigned BR_RST  = 4;

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } brg_sel_e;
endpackage

// File: rtl/brg_divisor_regs.sv
module brg_divisor_regs
  import brg_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned BW     = BR_W,
  parameter int unsigned RST_BR = BR_RST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel,
  input  logic [DW-1:0] wr_data,
  input  logic          lock,
  output logic [DW-1:0] rd_data,
  output logic [BW-1:0] br
);
  localparam int unsigned HI_W  = BW - DW;
  localparam int unsigned PAD_W = DW - HI_W;

  logic [BW-1:0] br_nxt;
  logic          wr_ok;

  assign wr_ok = wr_en && !lock;

  always_comb begin
    br_nxt = br;
    if (wr_ok) begin
      if (sel == SEL_HIGH) br_nxt[BW-1:DW] = wr_data[HI_W-1:0];
      else                 br_nxt[DW-1:0]  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     br <= BW'(RST_BR);
    else if (wr_ok) br <= br_nxt;
  end

  assign rd_data = (sel == SEL_HIGH) ? {{PAD_W{1'b0}}, br[BW-1:DW]} : br[DW-1:0];

  // R4: locked writes leave the divisor untouched
  assert_write_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> $stable(br));

  // R1: an accepted low-byte write lands in divisor bits 7..0
  assert_low_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock && sel == SEL_LOW) |=> (br[DW-1:0] == $past(wr_data)));
endmodule

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter int unsigned BW = brg_pkg::BR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [BW-1:0] br,
  output logic          ovs_evt,
  output logic          ovs_tick
);
  logic [BW-1:0] pcnt, pcnt_nxt;
  logic [BW-1:0] br_m1;

  assign br_m1   = br - BW'(1);
  assign ovs_evt = run && (pcnt >= br_m1);

  always_comb begin
    if (!run)         pcnt_nxt = '0;
    else if (ovs_evt) pcnt_nxt = '0;
    else              pcnt_nxt = pcnt + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      ovs_tick <= 1'b0;
    end else begin
      pcnt     <= pcnt_nxt;
      ovs_tick <= ovs_evt;
    end
  end

  // R7: zero divisor never yields a tick
  assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br == '0) |=> !ovs_tick);

  // R5: the tick is a single-clock pulse unless the divisor is 1
  assert_ovs_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovs_tick && br != BW'(1)) |=> !ovs_tick);
endmodule

// File: rtl/brg_bit_counter.sv
module brg_bit_counter #(
  parameter int unsigned OW = brg_pkg::OSR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ovs_evt,
  input  logic [OW-1:0] osr,
  output logic          bit_tick
);
  logic [OW-1:0] ocnt, ocnt_nxt;
  logic          bit_evt;

  assign bit_evt = ovs_evt && (ocnt >= osr);

  always_comb begin
    ocnt_nxt = ocnt;
    if (!run)         ocnt_nxt = '0;
    else if (bit_evt) ocnt_nxt = '0;
    else if (ovs_evt) ocnt_nxt = ocnt + OW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt     <= '0;
      bit_tick <= 1'b0;
    end else begin
      ocnt     <= ocnt_nxt;
      bit_tick <= bit_evt;
    end
  end

  // R8: stopped generator holds the oversample count at its start
  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ocnt == '0));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import brg_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned BW = BR_W,
  parameter int unsigned OW = OSR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic [OW-1:0] osr,
  output logic          ovs_tick,
  output logic          bit_tick
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          en_any;
  logic          armed, armed_nxt;
  logic          run;
  logic          ovs_evt;
  logic [BW-1:0] br;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign en_any    = tx_en || rx_en;
  assign armed_nxt = armed || en_any;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else if (en_any) armed <= armed_nxt;
  end

  assign run = armed && en_any && (br != '0);

  brg_divisor_regs #(.DW(DW), .BW(BW), .RST_BR(BR_RST)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_we),
    .sel     (reg_sel),
    .wr_data (reg_wdata),
    .lock    (en_any),
    .rd_data (reg_rdata),
    .br      (br)
  );

  brg_prescaler #(.BW(BW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .br       (br),
    .ovs_evt  (ovs_evt),
    .ovs_tick (ovs_tick)
  );

  brg_bit_counter #(.OW(OW)) u_bit (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .ovs_evt  (ovs_evt),
    .osr      (osr),
    .bit_tick (bit_tick)
  );

  // R3: nothing ticks before the first enable
  assert_idle_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !armed |-> (!ovs_tick && !bit_tick));

  // R6: a bit tick always coincides with an oversample tick
  assert_bit_on_ovs_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_tick |-> ovs_tick);

  // R8: with both enables low the next cycle is quiet
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_any |=> (!ovs_tick && !bit_tick));
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we, reg_sel;
  logic [7:0] reg_wdata, reg_rdata;
  logic       tx_en, rx_en;
  logic [4:0] osr;
  logic       ovs_tick, bit_tick;

  always #2.5 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_en(tx_en), .rx_en(rx_en),
    .osr(osr), .ovs_tick(ovs_tick), .bit_tick(bit_tick)
  );

  int checks = 0;
  int fails  = 0;
  int exp_ovs[$];
  int exp_bit[$];
  bit meas = 0;
  longint cyc = 0;
  longint ovs_last, bit_last;
  bit ovs_seen, bit_seen;
  int ovs_total = 0;
  int bit_total = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: samples 2 ns after each rising edge, pops expected spacings
  always @(posedge clk) begin
    #2;
    cyc++;
    if (ovs_tick) ovs_total++;
    if (bit_tick) bit_total++;
    if (!meas) begin
      ovs_seen = 0;
      bit_seen = 0;
    end else begin
      if (ovs_tick) begin
        if (ovs_seen && exp_ovs.size() > 0) begin
          int e;
          e = exp_ovs.pop_front();
          chk((cyc - ovs_last) == e, "R5 ovs spacing", cyc - ovs_last, e);
        end
        ovs_last = cyc;
        ovs_seen = 1;
      end
      if (bit_tick) begin
        if (bit_seen && exp_bit.size() > 0) begin
          int e;
          e = exp_bit.pop_front();
          chk((cyc - bit_last) == e, "R6 bit spacing", cyc - bit_last, e);
        end
        bit_last = cyc;
        bit_seen = 1;
      end
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input bit sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic quiet_chk(input int n, input string tag);
    int o0, b0;
    repeat (2) @(negedge clk);
    o0 = ovs_total; b0 = bit_total;
    repeat (n) @(negedge clk);
    chk((ovs_total - o0) + (bit_total - b0) == 0, tag, (ovs_total - o0) + (bit_total - b0), 0);
  endtask

  // driver: configures the divisor and pushes the expected spacings
  task automatic measure(input int br, input int ratio, input bit write_div, input bit use_rx);
    int nov, bitp;
    @(negedge clk);
    tx_en = 0; rx_en = 0;
    if (write_div) begin
      wr(1'b1, 8'((br >> 8) & 31));
      wr(1'b0, 8'(br & 255));
    end
    rd_chk(1'b0, 8'(br & 255), "R1 low readback");
    rd_chk(1'b1, 8'((br >> 8) & 31), "R1 high readback");
    osr = 5'(ratio);
    bitp = br * (ratio + 1);
    nov = (ratio + 1) * 3 < 8 ? (ratio + 1) * 3 : 8;
    for (int i = 0; i < nov; i++) exp_ovs.push_back(br);
    for (int i = 0; i < 3; i++) exp_bit.push_back(bitp);
    @(negedge clk);
    meas = 1;
    if (use_rx) rx_en = 1; else tx_en = 1;
    for (int t = 0; t < bitp * 5 + 20; t++) begin
      if (exp_ovs.size() == 0 && exp_bit.size() == 0) break;
      @(negedge clk);
    end
    chk(exp_ovs.size() == 0 && exp_bit.size() == 0, "R5 R6 spacings seen",
        exp_ovs.size() + exp_bit.size(), 0);
    exp_ovs.delete();
    exp_bit.delete();
    meas = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    tx_en = 0; rx_en = 0; osr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    rd_chk(1'b0, 8'h04, "R2 reset low byte");
    rd_chk(1'b1, 8'h00, "R2 reset high byte");
    quiet_chk(100, "R3 no ticks before first enable");

    measure(4, 0, 1'b0, 1'b0);     // reset divisor, tx enable
    tx_en = 0;
    quiet_chk(60, "R8 quiet after disable");

    measure(1, 0, 1'b1, 1'b1);     // every clock, rx enable
    measure(7, 3, 1'b1, 1'b0);
    measure(3, 31, 1'b1, 1'b1);    // largest oversampling
    measure(257, 1, 1'b1, 1'b0);   // needs the high byte

    // R4: writes blocked under each enable, checked through readback
    tx_en = 1; rx_en = 0;
    wr(1'b0, 8'h99);
    rd_chk(1'b0, 8'h01, "R4 low write ignored under tx_en");
    tx_en = 0; rx_en = 1;
    wr(1'b1, 8'h0F);
    rd_chk(1'b1, 8'h01, "R4 high write ignored under rx_en");
    rx_en = 0;

    // R1: upper bits of the high byte read as zero
    @(negedge clk);
    wr(1'b1, 8'hFF);
    rd_chk(1'b1, 8'h1F, "R1 high byte bits 7..5 read 0");

    // R7: zero divisor gives no ticks
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    rd_chk(1'b0, 8'h00, "R1 zero low readback");
    @(negedge clk);
    rx_en = 1;
    quiet_chk(200, "R7 no ticks with zero divisor");
    rx_en = 0;

    // R8: re-enable after stop restarts with full spacing
    measure(5, 2, 1'b1, 1'b0);
    tx_en = 0;
    quiet_chk(40, "R8 quiet after second disable");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule